// File: doc/BRIEF.md
# Dual-Mode Complex Sample Input Assembler

This block sits at the data input of a quadrature upconverter. It turns the sample stream on an 18-bit input bus into complete complex samples, each an I value and a Q value. It hands each sample to the interpolation path together with a one-cycle valid strobe. Data is taken on the rising edge of the data clock, and only while the transmit-enable framing input is high.

The block has two ways of reading the same bus. In word mode, every enabled clock carries one 18-bit word: the first word after enable rises is I, the next is Q, and the pattern repeats. In bitstream mode, two bus pins carry the I and Q bitstreams side by side, MSB first, 16 bits per word. The other sixteen pins are not used. Both lanes finish a word on the same clock. The 16-bit word is sign-preserving: it is placed at the top of the 18-bit output with two zero bits below. In both modes the output has the same form.

The mode input is taken only while transmit-enable is low. Lowering transmit-enable also throws away any partly collected sample, so the next enabled clock starts a fresh I word or a fresh bit count.

Top module: `iq_input_assembler`

## Requirements
- R1: After a synchronous active-high reset, out_valid, out_i and out_q are all zero, and the block is in word mode.
- R2: In word mode (mode_sel was 0 on the last cycle with tx_en low), the first word sampled after tx_en rises is I and the next is Q. One clock after the Q word is sampled, out_valid is high for one cycle, with out_i equal to the I word and out_q equal to the Q word.
- R3: In word mode, with tx_en held high, pairs repeat back to back. out_valid is low on the output cycle that follows each I word.
- R4: Bus values present while tx_en is low are never captured and never reach the outputs.
- R5: Lowering tx_en after an I word, including on the clock where its Q word would be sampled, discards that I word. No out_valid results, and the next enabled word is taken as I.
- R6: In bitstream mode (mode_sel was 1 on the last cycle with tx_en low), bus bit 0 carries I and bus bit 1 carries Q, MSB first. On the clock after the 16th enabled bit, out_valid pulses with both words.
- R7: In bitstream mode, out_i[17:2] and out_q[17:2] hold the 16-bit words unchanged (two's complement), and bits 1:0 are zero.
- R8: In bitstream mode, bus bits 17:2 have no effect on the outputs.
- R9: In bitstream mode, lowering tx_en part way through a word discards the collected bits. The bit count restarts at the next enabled clock.
- R10: mode_sel changes made while tx_en is high, including on the clock where tx_en rises, have no effect until tx_en has been low for a clock.
- R11: out_valid never stays high for two consecutive cycles, and out_i and out_q keep their values between pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Data clock; all capture on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| tx_en | input | 1 | Transmit-enable framing; data taken only while high |
| bus_in | input | 18 | Word bus, or two bitstream lanes on bits 1:0 |
| mode_sel | input | 1 | 0 selects word mode, 1 selects bitstream mode |
| out_i | output | 18 | Real part of the last completed sample |
| out_q | output | 18 | Imaginary part of the last completed sample |
| out_valid | output | 1 | One-cycle strobe marking a new sample |

## Verification
Two things can land on the same clock: a sample completing, and tx_en falling. The bench drives an I word and then lowers tx_en exactly on the clock where the Q word would have been sampled. It checks that no strobe appears and that the next enabled word is taken as I. A second collision is a mode_sel change on the very clock tx_en rises. The bench judges it by checking that the following sixteen clocks still assemble a correct bitstream sample rather than a word pair. A mode flip in the middle of a bitstream word is judged the same way.

// File: rtl/iqa_pkg.sv
package iqa_pkg;
  typedef enum logic {
    MODE_WORD = 1'b0,
    MODE_BITS = 1'b1
  } iqa_mode_e;

  localparam int unsigned IQA_BUS_W  = 18;
  localparam int unsigned IQA_SER_W  = 16;
endpackage

// File: rtl/iqa_word_pairer.sv
module iqa_word_pairer #(
  parameter int unsigned W = 18
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [W-1:0] din,
  output logic         pair_done,
  output logic [W-1:0] i_word,
  output logic [W-1:0] q_word
);
  logic         have_i;
  logic [W-1:0] i_hold;

  always_ff @(posedge clk) begin
    if (rst) begin
      have_i <= 1'b0;
      i_hold <= '0;
    end else if (!en) begin
      have_i <= 1'b0;
    end else begin
      have_i <= ~have_i;
      if (!have_i) i_hold <= din;
    end
  end

  assign pair_done = en && have_i;
  assign i_word    = i_hold;
  assign q_word    = din;

  // R2: a completed pair always follows an enabled I-capture clock
  a_r2_pair_after_i: assert property (@(posedge clk) disable iff (rst)
    pair_done |-> $past(en));
  // R5: a clock with enable low leaves no half pair behind
  a_r5_discard_partial: assert property (@(posedge clk) disable iff (rst)
    !en |=> !pair_done);
endmodule

// File: rtl/iqa_bit_deser.sv
module iqa_bit_deser #(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned OUT_W  = 18
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             lane_i,
  input  logic             lane_q,
  output logic             word_done,
  output logic [OUT_W-1:0] i_word,
  output logic [OUT_W-1:0] q_word
);
  localparam int unsigned CW  = $clog2(WORD_W);
  localparam int unsigned PAD = OUT_W - WORD_W;

  logic [CW-1:0]     bit_cnt;
  logic [WORD_W-2:0] sh_i;
  logic [WORD_W-2:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_cnt <= '0;
      sh_i    <= '0;
      sh_q    <= '0;
    end else if (!en) begin
      bit_cnt <= '0;
    end else begin
      bit_cnt <= (bit_cnt == CW'(WORD_W - 1)) ? '0 : bit_cnt + 1'b1;
      sh_i    <= {sh_i[WORD_W-3:0], lane_i};
      sh_q    <= {sh_q[WORD_W-3:0], lane_q};
    end
  end

  assign word_done = en && (bit_cnt == CW'(WORD_W - 1));
  assign i_word    = {sh_i, lane_i, {PAD{1'b0}}};
  assign q_word    = {sh_q, lane_q, {PAD{1'b0}}};

  // R9: a disabled clock always restarts the bit count
  a_r9_count_restart: assert property (@(posedge clk) disable iff (rst)
    !en |=> !word_done);
  // R6: a finished word needs the previous clock to have been enabled
  a_r6_word_after_bits: assert property (@(posedge clk) disable iff (rst)
    word_done |-> $past(en));
endmodule

// File: rtl/iq_input_assembler.sv
module iq_input_assembler #(
  parameter int unsigned BUS_W  = iqa_pkg::IQA_BUS_W,
  parameter int unsigned SER_W  = iqa_pkg::IQA_SER_W,
  parameter int unsigned I_PIN  = 0,
  parameter int unsigned Q_PIN  = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tx_en,
  input  logic [BUS_W-1:0] bus_in,
  input  logic             mode_sel,
  output logic [BUS_W-1:0] out_i,
  output logic [BUS_W-1:0] out_q,
  output logic             out_valid
);
  import iqa_pkg::*;

  iqa_mode_e        mode_q;
  logic             word_en, bits_en;
  logic             w_done, b_done;
  logic [BUS_W-1:0] w_i, w_q, b_i, b_q;

  always_ff @(posedge clk) begin
    if (rst)         mode_q <= MODE_WORD;
    else if (!tx_en) mode_q <= iqa_mode_e'(mode_sel);
  end

  assign word_en = tx_en && (mode_q == MODE_WORD);
  assign bits_en = tx_en && (mode_q == MODE_BITS);

  iqa_word_pairer #(.W(BUS_W)) u_pair (
    .clk(clk), .rst(rst), .en(word_en), .din(bus_in),
    .pair_done(w_done), .i_word(w_i), .q_word(w_q)
  );

  iqa_bit_deser #(.WORD_W(SER_W), .OUT_W(BUS_W)) u_deser (
    .clk(clk), .rst(rst), .en(bits_en),
    .lane_i(bus_in[I_PIN]), .lane_q(bus_in[Q_PIN]),
    .word_done(b_done), .i_word(b_i), .q_word(b_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_i     <= '0;
      out_q     <= '0;
    end else begin
      out_valid <= w_done || b_done;
      if (w_done) begin
        out_i <= w_i;
        out_q <= w_q;
      end else if (b_done) begin
        out_i <= b_i;
        out_q <= b_q;
      end
    end
  end

  // R11: strobe lasts a single clock
  a_r11_single_pulse: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);
  // R11: data held steady between strobes
  a_r11_hold: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> $stable(out_i) && $stable(out_q));
  // R10: mode frozen while enable stays high
  a_r10_mode_frozen: assert property (@(posedge clk) disable iff (rst)
    $past(tx_en) |-> $stable(mode_q));
  // R7: bitstream samples carry zero low bits
  a_r7_low_bits_zero: assert property (@(posedge clk) disable iff (rst)
    (out_valid && mode_q == MODE_BITS) |-> (out_i[1:0] == 2'b00 && out_q[1:0] == 2'b00));
endmodule

// File: tb/iq_input_assembler_test.sv
module iq_input_assembler_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tx_en = 1'b0;
  logic [17:0] bus_in = '0;
  logic        mode_sel = 1'b0;
  logic [17:0] out_i, out_q;
  logic        out_valid;
  int          total = 0;
  int          bad = 0;
  int          cycles = 0;
  bit          finished = 1'b0;

  always #10 clk = ~clk;

  iq_input_assembler uut (
    .clk(clk), .rst(rst), .tx_en(tx_en), .bus_in(bus_in),
    .mode_sel(mode_sel), .out_i(out_i), .out_q(out_q), .out_valid(out_valid)
  );

  localparam logic [35:0] VEC [4] = '{
    {18'h3FFFF, 18'h00000},
    {18'h20000, 18'h1FFFF},
    {18'h12345, 18'h2ABCD},
    {18'h00001, 18'h3FFFE}
  };

  task automatic tick(input logic en, input logic [17:0] d);
    tx_en  = en;
    bus_in = d;
    @(posedge clk);
    #2;
  endtask

  task automatic check(input string req, input logic [36:0] act, input logic [36:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send_bits(input logic [15:0] wi, input logic [15:0] wq,
                           input logic [15:0] junk, input string req);
    for (int b = 15; b >= 0; b--) begin
      tick(1'b1, {junk, wq[b], wi[b]});
      if (b != 0) check({req, " no early strobe"}, {36'h0, out_valid}, 37'h0);
    end
    check(req, {out_valid, out_i, out_q}, {1'b1, wi, 2'b00, wq, 2'b00});
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !finished) begin
      finished = 1'b1;
      bad++;
      total++;
      $display("FAIL watchdog actual=%0d expected<20000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #2;
    tick(1'b0, '0);
    tick(1'b0, '0);
    // R1 reset state
    check("R1", {out_valid, out_i, out_q}, 37'h0);
    rst = 1'b0;
    tick(1'b0, 18'h3FFFF);
    // R4: bus while disabled
    check("R4 idle", {out_valid, out_i, out_q}, 37'h0);

    // table walk: R2 / R3, back-to-back pairs
    for (int k = 0; k < 4; k++) begin
      tick(1'b1, VEC[k][35:18]);
      if (k > 0) check("R3 no strobe after I", {36'h0, out_valid}, 37'h0);
      tick(1'b1, VEC[k][17:0]);
      check("R2 pair", {out_valid, out_i, out_q}, {1'b1, VEC[k]});
    end
    tick(1'b0, 18'h15555);
    // R11: hold after strobe
    check("R11 hold", {out_valid, out_i, out_q}, {1'b0, VEC[3]});

    // R5: drop enable after an I word, then restart
    tick(1'b1, 18'h0AAAA);
    tick(1'b0, 18'h0BBBB);
    check("R5 drop on Q clock", {36'h0, out_valid}, 37'h0);
    tick(1'b1, 18'h01111);
    check("R5 restart is I", {36'h0, out_valid}, 37'h0);
    tick(1'b1, 18'h02222);
    check("R5 fresh pair", {out_valid, out_i, out_q}, {1'b1, 18'h01111, 18'h02222});
    tick(1'b0, '0);

    // R10: select bitstream mode while disabled, flip it back as enable rises
    mode_sel = 1'b1;
    tick(1'b0, '0);
    mode_sel = 1'b0;
    send_bits(16'h8001, 16'h7FFE, 16'hA5C3, "R6 R7 R10 first word");
    send_bits(16'hFFFF, 16'h0000, 16'h5A3C, "R6 R8 second word");

    // R9: partial word dropped
    tick(1'b0, '0);
    mode_sel = 1'b1;
    tick(1'b0, '0);
    for (int b = 0; b < 7; b++) tick(1'b1, 18'h3FFFF);
    tick(1'b0, 18'h3FFFF);
    check("R9 no strobe", {36'h0, out_valid}, 37'h0);
    mode_sel = 1'b1;
    tick(1'b1, {16'hFFFF, 1'b0, 1'b1});
    mode_sel = 1'b0;  // R10: mid-word flip ignored
    for (int b = 14; b >= 0; b--) begin
      logic [15:0] wi = 16'h9234;
      logic [15:0] wq = 16'h4C01;
      tick(1'b1, {16'hFFFF, wq[b], wi[b]});
    end
    check("R9 R10 word after drop", {out_valid, out_i, out_q},
          {1'b1, 16'h9234, 2'b00, 16'h4C01, 2'b00});

    // back to word mode after a disabled clock (R10)
    tick(1'b0, '0);
    tick(1'b1, 18'h3ABCD);
    tick(1'b1, 18'h00003);
    check("R10 word mode again", {out_valid, out_i, out_q}, {1'b1, 18'h3ABCD, 18'h00003});
    tick(1'b0, '0);
    check("R11 one cycle", {36'h0, out_valid}, 37'h0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule